// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 32 interrupt request lines, filters them through a per-source mask, and drives a single processor interrupt request. Sixteen programmable slots each bind one source number to a stored handler address. Among the slots whose source is currently live, the lowest-numbered slot wins. Its handler address is presented to the processor as the current vector. When no slot matches, a separate default handler address is presented instead.

Software programs the block through a simple word-addressed register bus. A handler reads the current vector to learn where to jump. That read freezes the winning priority level. From then on, only a strictly higher-priority slot can change the reported vector. A write to the current-vector address marks the end of service and releases the freeze. Reads return data combinationally in the same cycle as the strobe. Writes and read side effects take place at the next rising clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every mask bit, every slot control and the priority freeze are cleared, and the default and slot handler registers read zero. As a result, `irq_o` stays low and `vec_o` reads zero for any request pattern.
- R2: `irq_o` is high in exactly the cycles in which some source n has its request line high and bit n of the mask register (address 0x00) set. Bit 17 (0x00020000) masks in source 17.
- R3: In a slot control register, bit 5 enables the slot and bits 4:0 select the source it serves. A slot is active only when it is enabled, its source is masked in and that source is requesting. A disabled slot never supplies a vector.
- R4: `vec_o`, and a bus read of address 0x01, return the handler register of the lowest-numbered active slot. Slot 0 has the highest priority.
- R5: With no eligible active slot and no freeze held, `vec_o` returns the default handler register (address 0x02).
- R6: A bus read of address 0x01 freezes the current winning level. While frozen, slots at that level or lower in priority cannot change `vec_o`. If nothing higher is active, the value captured by the read is returned, even after its source drops.
- R7: While frozen, an active slot with a smaller number than the frozen level replaces the reported vector at once. A further read of 0x01 moves the freeze to that level.
- R8: A bus write to address 0x01 releases the freeze whatever the data, and normal priority selection resumes.
- R9: Slot controls sit at 0x10+s and read back only their 6 stored bits, zero-extended. Slot handlers sit at 0x20+s and the mask at 0x00, and all of them read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | 32 | Interrupt request lines, one per source, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0x01 only) |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 32 | Current handler address |

## Verification
`irq_o`, `vec_o` and `bus_rdata` are combinational in the request lines and the stored registers, so the bench samples them five nanoseconds after it changes `src_req`, in the same low clock phase. A register write or a freeze read takes effect at the one rising edge while its strobe is high. Every check that depends on such an access is therefore made after the following falling edge. After reset is released, the internal two-flop synchroniser holds the block cleared for two more edges, and the bench waits past them before it drives the bus.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] A_CUR  = 8'h01;
  localparam logic [ADDR_W-1:0] A_DFLT = 8'h02;
  localparam logic [3:0] PAGE_CTL = 4'h1;
  localparam logic [3:0] PAGE_VEC = 4'h2;
endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
  import ivc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int SLOTS = 16,
  parameter int DW    = 32,
  localparam int SRC_W = $clog2(NSRC),
  localparam int CTL_W = SRC_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DW-1:0]                 wdata,
  output logic [NSRC-1:0]               mask_o,
  output logic [SLOTS-1:0][CTL_W-1:0]   ctl_o,
  output logic [SLOTS-1:0][DW-1:0]      hvec_o,
  output logic [DW-1:0]                 dflt_o,
  output logic [DW-1:0]                 rdata_o
);
  logic [NSRC-1:0]             mask_q, mask_d;
  logic [SLOTS-1:0][CTL_W-1:0] ctl_q, ctl_d;
  logic [SLOTS-1:0][DW-1:0]    hv_q, hv_d;
  logic [DW-1:0]               dflt_q, dflt_d;
  logic                        in_range, ctl_hit, vec_hit;
  logic [3:0]                  sel;

  assign sel      = addr[3:0];
  assign in_range = int'(sel) < SLOTS;
  assign ctl_hit  = wr && addr[ADDR_W-1:4] == PAGE_CTL && in_range;
  assign vec_hit  = wr && addr[ADDR_W-1:4] == PAGE_VEC && in_range;

  always_comb begin
    mask_d = mask_q;
    ctl_d  = ctl_q;
    hv_d   = hv_q;
    dflt_d = dflt_q;
    if (wr && addr == A_MASK) mask_d = wdata[NSRC-1:0];
    if (wr && addr == A_DFLT) dflt_d = wdata;
    if (ctl_hit) ctl_d[sel] = wdata[CTL_W-1:0];
    if (vec_hit) hv_d[sel] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctl_q  <= '0;
      hv_q   <= '0;
      dflt_q <= '0;
    end else begin
      mask_q <= mask_d;
      ctl_q  <= ctl_d;
      hv_q   <= hv_d;
      dflt_q <= dflt_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr == A_MASK) rdata_o[NSRC-1:0] = mask_q;
    else if (addr == A_DFLT) rdata_o = dflt_q;
    else if (addr[ADDR_W-1:4] == PAGE_CTL && in_range) rdata_o[CTL_W-1:0] = ctl_q[sel];
    else if (addr[ADDR_W-1:4] == PAGE_VEC && in_range) rdata_o = hv_q[sel];
  end

  assign mask_o = mask_q;
  assign ctl_o  = ctl_q;
  assign hvec_o = hv_q;
  assign dflt_o = dflt_q;

  // R9: a slot control write is stored as its low six bits
  assert_ctl_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> ctl_q[$past(sel)] == $past(wdata[CTL_W-1:0]));
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int SLOTS = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LVL_W  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]  act,
  input  logic [LVL_W-1:0]  limit,
  output logic              found,
  output logic [SLOT_W-1:0] idx
);
  logic [SLOTS-1:0] elig;

  for (genvar g = 0; g < SLOTS; g++) begin : g_elig
    assign elig[g] = act[g] && (LVL_W'(g) < limit);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end

  // R4: the reported winner is an active slot inside the allowed range
  always_comb begin
    assert_winner_active_R4: assert (!found || (act[idx] && LVL_W'(idx) < limit));
  end
endmodule

// File: rtl/ivc_lock.sv
module ivc_lock #(
  parameter int SLOTS = 16,
  parameter int DW    = 32,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LVL_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cur,
  input  logic              ack,
  input  logic              found,
  input  logic [SLOT_W-1:0] idx,
  input  logic [DW-1:0]     cur_vec,
  output logic              locked_o,
  output logic [LVL_W-1:0]  limit_o,
  output logic [DW-1:0]     held_o
);
  localparam logic [LVL_W-1:0] OPEN = LVL_W'(SLOTS);

  logic             locked_q, locked_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [DW-1:0]    held_q, held_d;

  always_comb begin
    locked_d = locked_q;
    lvl_d    = lvl_q;
    held_d   = held_q;
    if (ack) begin
      locked_d = 1'b0;
      lvl_d    = OPEN;
    end else if (rd_cur) begin
      locked_d = 1'b1;
      held_d   = cur_vec;
      if (found) lvl_d = LVL_W'(idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      lvl_q    <= OPEN;
      held_q   <= '0;
    end else begin
      locked_q <= locked_d;
      lvl_q    <= lvl_d;
      held_q   <= held_d;
    end
  end

  assign locked_o = locked_q;
  assign limit_o  = lvl_q;
  assign held_o   = held_q;

  // R8: the acknowledge write drops the freeze on the next edge
  assert_ack_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !locked_q);
  // R6: while frozen the selector only returns a strictly higher slot
  assert_frozen_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && found) |-> LVL_W'(idx) < lvl_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int SLOTS = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic [DW-1:0]     vec_o
);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int CTL_W  = SRC_W + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LVL_W  = $clog2(SLOTS + 1);

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [NSRC-1:0]             mask;
  logic [SLOTS-1:0][CTL_W-1:0] ctl;
  logic [SLOTS-1:0][DW-1:0]    hvec;
  logic [DW-1:0]               dflt, cfg_rdata, held, cur_vec;
  logic [SLOTS-1:0]            act;
  logic                        found, locked, rd_cur, ack;
  logic [SLOT_W-1:0]           idx;
  logic [LVL_W-1:0]            limit;

  ivc_cfg_regs #(.NSRC(NSRC), .SLOTS(SLOTS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask_o(mask), .ctl_o(ctl), .hvec_o(hvec), .dflt_o(dflt), .rdata_o(cfg_rdata)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [SRC_W-1:0] src_sel;
    assign src_sel = ctl[s][SRC_W-1:0];
    assign act[s]  = ctl[s][CTL_W-1] && mask[src_sel] && src_req[src_sel];
  end

  ivc_pick #(.SLOTS(SLOTS)) u_pick (
    .act(act), .limit(limit), .found(found), .idx(idx)
  );

  assign rd_cur = bus_rd && bus_addr == A_CUR;
  assign ack    = bus_wr && bus_addr == A_CUR;

  ivc_lock #(.SLOTS(SLOTS), .DW(DW)) u_lock (
    .clk(clk), .rst_n(rst_q), .rd_cur(rd_cur), .ack(ack), .found(found),
    .idx(idx), .cur_vec(cur_vec), .locked_o(locked), .limit_o(limit), .held_o(held)
  );

  always_comb begin
    if (found)       cur_vec = hvec[idx];
    else if (locked) cur_vec = held;
    else             cur_vec = dflt;
  end

  assign irq_o     = |(src_req & mask);
  assign vec_o     = cur_vec;
  assign bus_rdata = (bus_addr == A_CUR) ? cur_vec : cfg_rdata;

  // R2: any active slot implies a raised processor request
  assert_irq_covers_slots_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (|act) |-> irq_o);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_req;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, vec_o;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  localparam logic [31:0] DFLT = 32'hDEAD_0000;

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] vec;
    logic        irq;
  } row_t;

  // slot1: src17 -> 0x1000, slot3: src6 -> 0x3000,
  // slot5: src15 disabled -> 0x5000, slot9: src15 -> 0x9000; mask = 17,15,6
  localparam row_t TBL [8] = '{
    '{32'h0000_0000, DFLT,         1'b0},
    '{32'h0002_0000, 32'h0000_1000, 1'b1},
    '{32'h0000_0040, 32'h0000_3000, 1'b1},
    '{32'h0002_0040, 32'h0000_1000, 1'b1},
    '{32'h0000_8000, 32'h0000_9000, 1'b1},
    '{32'h0000_4000, DFLT,         1'b0},
    '{32'h0000_4040, 32'h0000_3000, 1'b1},
    '{32'h0010_0000, DFLT,         1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_req(input logic [31:0] r);
    @(negedge clk);
    src_req = r;
    #5;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_req = '0; bus_wr = 0; bus_rd = 0; bus_addr = 8'h01; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: cleared state at the ports
    set_req(32'hFFFF_FFFF);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 vec after reset", vec_o, 32'h0);
    rd(8'h00, d); chk("R1 mask cleared", d, 32'h0);
    rd(8'h11, d); chk("R1 slot ctl cleared", d, 32'h0);
    set_req(32'h0);

    // configuration
    wr(8'h02, DFLT);
    wr(8'h00, 32'h0002_8040);
    wr(8'h11, 32'h20 | 17); wr(8'h21, 32'h0000_1000);
    wr(8'h13, 32'h20 | 6);  wr(8'h23, 32'h0000_3000);
    wr(8'h15, 32'h00 | 15); wr(8'h25, 32'h0000_5000);
    wr(8'h19, 32'h20 | 15); wr(8'h29, 32'h0000_9000);

    // R9: readback
    rd(8'h11, d); chk("R9 slot1 ctl", d, 32'h31);
    rd(8'h21, d); chk("R9 slot1 handler", d, 32'h1000);
    rd(8'h00, d); chk("R9 mask", d, 32'h0002_8040);
    wr(8'h17, 32'hFFFF_FFC5);
    rd(8'h17, d); chk("R9 ctl keeps six bits", d, 32'h05);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < 8; i++) begin
      set_req(TBL[i].req);
      bus_addr = 8'h01;
      #1;
      chk($sformatf("R4 R5 vec row %0d", i), vec_o, TBL[i].vec);
      chk($sformatf("R3 rdata row %0d", i), bus_rdata, TBL[i].vec);
      chk($sformatf("R2 irq row %0d", i), {31'b0, irq_o}, {31'b0, TBL[i].irq});
    end

    // R6 R7 R8: freeze and release
    set_req(32'h0000_0040);
    rd(8'h01, d); chk("R4 freeze read", d, 32'h3000);
    set_req(32'h0000_8000);
    chk("R6 lower slot blocked", vec_o, 32'h3000);
    set_req(32'h0002_8000);
    chk("R7 higher slot replaces", vec_o, 32'h1000);
    rd(8'h01, d); chk("R7 refreeze read", d, 32'h1000);
    set_req(32'h0000_8000);
    chk("R6 held after drop", vec_o, 32'h1000);
    wr(8'h01, 32'h1234_5678);
    #5 chk("R8 release", vec_o, 32'h9000);

    set_req(32'h0);
    rd(8'h01, d); chk("R5 default read", d, DFLT);
    set_req(32'h0000_8000);
    chk("R6 default freeze open", vec_o, 32'h9000);
    wr(8'h01, 32'h0);

    // R1: reset in mid-run
    set_req(32'h0002_0000);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk("R1 irq after rerun reset", {31'b0, irq_o}, 32'h0);
    chk("R1 vec after rerun reset", vec_o, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule